// File: doc/BRIEF.md
# Cascaded Multi-Bus Priority Picker

This block arbitrates several shared result buses among a row of function units in a single cycle. Each function unit raises one bit of a request vector. The block returns one grant vector per bus, with one bit for each function unit. A grant vector is one-hot when its bus is used and all-zero when it is not. A valid flag accompanies each bus.

The picker is a chain of identical stages. Each stage turns its request pool into a binary index with a priority encoder, then expands that index back into a one-hot grant with a decoder. It removes its winner from the pool before passing the pool to the next stage. Bus 0 therefore goes to the most urgent requester, bus 1 to the next one, and so on. A parameter selects whether the grants leave combinationally or through one register stage.

Top module: `multibus_picker`

## Requirements
- R1: The grant for bus 0 is the active request with the lowest index. Lower index means higher priority. Bit i of each grant vector belongs to function unit i.
- R2: The grant for bus k is the (k+1)-th lowest-index active request. Bus k occupies bits [k*NUM_REQ +: NUM_REQ] of `grant_o`.
- R3: No function unit is granted more than one bus in the same cycle. Every granted bit corresponds to an active request.
- R4: `valid_o[k]` is high exactly when at least k+1 requests are active. When it is low, the grant vector of bus k is all-zero.
- R5: When more requests are active than there are buses, the requests beyond the NUM_BUS lowest-index ones receive no grant.
- R6: With REG_OUT=1, grants and valids reflect the request vector sampled at the previous rising clock edge. They hold steady between edges.
- R7: With REG_OUT=1, an active-low asynchronous reset forces all grants and valid flags to zero.
- R8: With REG_OUT=0, grants and valids follow the request vector with no clock edge, and they do so even while reset is asserted.
- R9: The valid flags fill from bus 0 upward: `valid_o[k]` high implies `valid_o[k-1]` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| req_i | input | NUM_REQ | Request bit of each function unit |
| grant_o | output | NUM_BUS*NUM_REQ | One-hot grant per bus, bus k in bits [k*NUM_REQ +: NUM_REQ] |
| valid_o | output | NUM_BUS | Bus k carries a grant |

## Verification
The hardest case to reach is a dense request pattern in which later stages see a pool that earlier stages have already thinned out. Examples are patterns with the active bits packed at the top, or with more active bits than buses. Only these patterns exercise the masking between stages and the dropping of surplus requests. The bench uses six function units and three buses, so it can walk every one of the 64 request patterns through both the combinational and the registered variant. This covers every depth of masking and every overflow count. Reset is also asserted while all requests are active, which shows that the output register clears regardless of its input.

// File: rtl/bus_pick_pkg.sv
package bus_pick_pkg;

    // Width of a binary index able to address n function units
    function automatic int idx_width(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/prio_enc.sv
module prio_enc
    import bus_pick_pkg::*;
#(
    parameter int NUM_REQ = 8,
    localparam int IDX_W  = idx_width(NUM_REQ)
) (
    input  logic [NUM_REQ-1:0] pool_i,
    output logic [IDX_W-1:0]   idx_o,
    output logic               any_o
);

    // Scan from the top so the lowest set bit is written last and wins
    always_comb begin
        idx_o = '0;
        for (int i = NUM_REQ - 1; i >= 0; i--) begin
            if (pool_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end

    assign any_o = |pool_i;

endmodule

// File: rtl/onehot_dec.sv
module onehot_dec
    import bus_pick_pkg::*;
#(
    parameter int NUM_REQ = 8,
    localparam int IDX_W  = idx_width(NUM_REQ)
) (
    input  logic [IDX_W-1:0]   idx_i,
    input  logic               en_i,
    output logic [NUM_REQ-1:0] onehot_o
);

    always_comb begin
        for (int i = 0; i < NUM_REQ; i++) begin
            onehot_o[i] = en_i && (idx_i == IDX_W'(i));
        end
    end

endmodule

// File: rtl/pick_stage.sv
module pick_stage
    import bus_pick_pkg::*;
#(
    parameter int NUM_REQ = 8,
    localparam int IDX_W  = idx_width(NUM_REQ)
) (
    input  logic [NUM_REQ-1:0] pool_i,
    output logic [NUM_REQ-1:0] grant_o,
    output logic               valid_o,
    output logic [NUM_REQ-1:0] rest_o
);

    logic [IDX_W-1:0] win_idx;

    prio_enc #(.NUM_REQ(NUM_REQ)) u_enc (
        .pool_i (pool_i),
        .idx_o  (win_idx),
        .any_o  (valid_o)
    );

    onehot_dec #(.NUM_REQ(NUM_REQ)) u_dec (
        .idx_i    (win_idx),
        .en_i     (valid_o),
        .onehot_o (grant_o)
    );

    // Remove this stage's winner before the next bus is picked
    assign rest_o = pool_i & ~grant_o;

endmodule

// File: rtl/multibus_picker.sv
module multibus_picker #(
    parameter int NUM_REQ = 8,
    parameter int NUM_BUS = 3,
    parameter bit REG_OUT = 1'b0,
    localparam int GNT_W  = NUM_BUS * NUM_REQ
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] req_i,
    output logic [GNT_W-1:0]   grant_o,
    output logic [NUM_BUS-1:0] valid_o
);

    logic [NUM_REQ-1:0] pool [NUM_BUS];
    logic [GNT_W-1:0]   grant_c;
    logic [NUM_BUS-1:0] valid_c;
    logic [NUM_REQ-1:0] leftover_unused;

    assign pool[0] = req_i;

    for (genvar k = 0; k < NUM_BUS; k++) begin : g_stage
        if (k < NUM_BUS - 1) begin : g_mid
            pick_stage #(.NUM_REQ(NUM_REQ)) u_stage (
                .pool_i  (pool[k]),
                .grant_o (grant_c[k*NUM_REQ +: NUM_REQ]),
                .valid_o (valid_c[k]),
                .rest_o  (pool[k+1])
            );
        end else begin : g_last
            pick_stage #(.NUM_REQ(NUM_REQ)) u_stage (
                .pool_i  (pool[k]),
                .grant_o (grant_c[k*NUM_REQ +: NUM_REQ]),
                .valid_o (valid_c[k]),
                .rest_o  (leftover_unused)
            );
        end
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                grant_o <= '0;
                valid_o <= '0;
            end else begin
                grant_o <= grant_c;
                valid_o <= valid_c;
            end
        end
    end else begin : g_comb
        logic unused_clk_rst;
        assign unused_clk_rst = ^{clk, rst_n};
        assign grant_o = grant_c;
        assign valid_o = valid_c;
    end

endmodule

// File: rtl/multibus_picker_chk.sv
module multibus_picker_chk #(
    parameter int NUM_REQ = 8,
    parameter int NUM_BUS = 3,
    parameter bit REG_OUT = 1'b0,
    localparam int GNT_W  = NUM_BUS * NUM_REQ
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_REQ-1:0] req_i,
    input logic [GNT_W-1:0]   grant_o,
    input logic [NUM_BUS-1:0] valid_o
);

    logic [NUM_REQ-1:0] req_ref;
    logic [NUM_REQ-1:0] low_bit;
    logic [NUM_REQ-1:0] all_grants;
    int                 exp_total;

    if (REG_OUT) begin : g_ref_reg
        logic [NUM_REQ-1:0] req_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) req_q <= '0;
            else        req_q <= req_i;
        end
        assign req_ref = req_q;
    end else begin : g_ref_comb
        assign req_ref = req_i;
    end

    assign low_bit = req_ref & (~req_ref + NUM_REQ'(1));

    always_comb begin
        all_grants = '0;
        for (int k = 0; k < NUM_BUS; k++) begin
            all_grants = all_grants | grant_o[k*NUM_REQ +: NUM_REQ];
        end
        exp_total = ($countones(req_ref) > NUM_BUS) ? NUM_BUS : $countones(req_ref);
    end

    assert_bus0_lowest_R1: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o[NUM_REQ-1:0] == low_bit);

    assert_grant_total_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant_o) == exp_total);

    assert_grant_subset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (all_grants & ~req_ref) == '0);

    for (genvar k = 0; k < NUM_BUS; k++) begin : g_bus
        assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(grant_o[k*NUM_REQ +: NUM_REQ]));

        assert_valid_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
            valid_o[k] == (|grant_o[k*NUM_REQ +: NUM_REQ]));

        if (k > 0) begin : g_fill
            assert_valid_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
                valid_o[k] |-> valid_o[k-1]);
        end

        for (genvar m = k + 1; m < NUM_BUS; m++) begin : g_pair
            assert_grant_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (grant_o[k*NUM_REQ +: NUM_REQ] & grant_o[m*NUM_REQ +: NUM_REQ]) == '0);
        end
    end

endmodule

bind multibus_picker multibus_picker_chk #(
    .NUM_REQ (NUM_REQ),
    .NUM_BUS (NUM_BUS),
    .REG_OUT (REG_OUT)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req_i),
    .grant_o (grant_o),
    .valid_o (valid_o)
);

// File: tb/sim_multibus_picker.sv
module sim_multibus_picker;

    localparam int NR = 6;
    localparam int NB = 3;
    localparam int GW = NR * NB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NR-1:0] req = '0;
    logic [GW-1:0] g_reg, g_cmb;
    logic [NB-1:0] v_reg, v_cmb;
    int            n_checks = 0;
    int            n_fail = 0;
    bit            done = 1'b0;

    always #10 clk = ~clk;

    multibus_picker #(.NUM_REQ(NR), .NUM_BUS(NB), .REG_OUT(1'b1)) u0 (
        .clk (clk), .rst_n (rst_n), .req_i (req), .grant_o (g_reg), .valid_o (v_reg)
    );

    multibus_picker #(.NUM_REQ(NR), .NUM_BUS(NB), .REG_OUT(1'b0)) u1 (
        .clk (clk), .rst_n (rst_n), .req_i (req), .grant_o (g_cmb), .valid_o (v_cmb)
    );

    // Expected {valid, grant}: the n-th lowest set bit goes to bus n while buses remain
    function automatic logic [GW+NB-1:0] model(input logic [NR-1:0] r);
        logic [GW-1:0] g;
        logic [NB-1:0] v;
        int            cnt;
        g = '0;
        v = '0;
        cnt = 0;
        for (int i = 0; i < NR; i++) begin
            if (r[i]) begin
                if (cnt < NB) begin
                    g[cnt*NR + i] = 1'b1;
                    v[cnt] = 1'b1;
                end
                cnt++;
            end
        end
        return {v, g};
    endfunction

    task automatic check_out(input string tag, input logic [GW-1:0] ag,
                             input logic [NB-1:0] av, input logic [GW+NB-1:0] ex);
        n_checks++;
        if ({av, ag} !== ex) begin
            n_fail++;
            $display("FAIL %s: got valid=%b grant=%h, expected valid=%b grant=%h",
                     tag, av, ag, ex[GW+NB-1:GW], ex[GW-1:0]);
        end
    endtask

    // R3 and R9 examined on the actual outputs against the driven request
    task automatic check_shape(input string which, input logic [GW-1:0] ag,
                               input logic [NB-1:0] av, input logic [NR-1:0] r);
        logic [NR-1:0] seen;
        logic          clash;
        logic          holes;
        seen = '0;
        clash = 1'b0;
        holes = 1'b0;
        for (int k = 0; k < NB; k++) begin
            if ((seen & ag[k*NR +: NR]) != '0) clash = 1'b1;
            seen = seen | ag[k*NR +: NR];
            if (k > 0 && av[k] && !av[k-1]) holes = 1'b1;
        end
        n_checks++;
        if (clash || ((seen & ~r) != '0)) begin
            n_fail++;
            $display("FAIL R3 %s: grants=%h overlap or exceed req=%b (expected disjoint subset)",
                     which, ag, r);
        end
        n_checks++;
        if (holes) begin
            n_fail++;
            $display("FAIL R9 %s: valid=%b, expected filled from bus 0", which, av);
        end
    endtask

    initial begin
        logic [NR-1:0] prev;
        // Reset phase: all requests active
        req = '1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        #1;
        check_out("R7 reset clears registered outputs", g_reg, v_reg, '0);
        check_out("R8 combinational output during reset", g_cmb, v_cmb, model('1));

        @(negedge clk);
        rst_n = 1'b1;
        req = '0;
        prev = '0;
        @(posedge clk);

        for (int p = 0; p < (1 << NR); p++) begin
            @(negedge clk);
            #1;
            check_out("R6 registered output after edge", g_reg, v_reg, model(prev));
            req = NR'(p);
            #1;
            check_out("R1/R2/R4/R5 combinational", g_cmb, v_cmb, model(req));
            check_out("R8 no edge needed", g_cmb, v_cmb, model(NR'(p)));
            check_out("R6 registered holds before edge", g_reg, v_reg, model(prev));
            check_shape("comb", g_cmb, v_cmb, req);
            check_shape("reg", g_reg, v_reg, prev);
            prev = req;
        end
        @(negedge clk);
        #1;
        check_out("R6 last pattern registered", g_reg, v_reg, model(prev));

        // Asynchronous reset with a full request vector
        req = '1;
        @(posedge clk);
        #2;
        check_out("R5 registered full load", g_reg, v_reg, model('1));
        rst_n = 1'b0;
        #1;
        check_out("R7 async reset mid-run", g_reg, v_reg, '0);
        @(posedge clk);
        #1;
        check_out("R7 reset holds over edge", g_reg, v_reg, '0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL all: watchdog expired, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule